// File: doc/BRIEF.md
# Pixel Stream Sequence Checker

This block sits after a packet parser. It watches the control events that the parser emits on a pixel stream: frame start, line start carrying data, data, line end carrying data, and frame end. Each event arrives as a one-hot strobe. An event that fits the legal order is forwarded one cycle later. An event that breaks the order is dropped, and a sticky stream-error flag is raised. After an error the checker waits for the next frame start before it accepts anything else.

A small run controller takes commands to disable, enable, reset or arm single-shot capture. In single-shot mode the checker turns itself off after it accepts one frame end. Two saturating counters record accepted line ends (lines processed) and accepted frame starts (frames output). The parser reset command clears both counters.

Top module: `pxs_order_guard`

## Requirements
- R1: During synchronous reset and on the first cycle after it, `stream_err`, `active`, `evt_out`, `line_cnt` and `frame_cnt` are all zero.
- R2: While `active` is low, events on `evt_in` are ignored. Nothing is forwarded, no error is raised and no counter moves.
- R3: Commands are applied when `cmd_valid` is high, with `cmd_op` coded as 0 disable, 1 enable, 2 reset, 3 single-shot. Enable and single-shot set `active` and restart the sequence so that a frame start is expected next. Disable clears `active`. Reset clears `active` and both counters. An event presented in a command cycle is ignored.
- R4: `evt_in` and `evt_out` use bit 0 for frame start, bit 1 for line start, bit 2 for data, bit 3 for line end and bit 4 for frame end. The legal successors are as follows:
  - frame start may be followed by line start or frame end;
  - line start may be followed by data or line end;
  - data may be followed only by line end;
  - line end may be followed by line start or frame end;
  - frame end may be followed only by frame start.

  A legal event appears on `evt_out` one cycle after it is sampled.
- R5: After reset, enable or single-shot, the first event must be a frame start. Any other event is a violation.
- R6: A violating event is not forwarded and sets `stream_err`. The checker then treats every event as a violation until the next frame start, which it accepts.
- R7: An `evt_in` value with more than one bit set is a violation.
- R8: `stream_err` stays set until `err_clr` is high in a cycle without a violation. If a violation and `err_clr` occur in the same cycle, the flag stays set.
- R9: `line_cnt` increments on each accepted line end. `frame_cnt` increments on each accepted frame start. Both update on the same edge that forwards the event.
- R10: The counters are `CNT_W` bits wide (default 32) and hold at all ones instead of wrapping.
- R11: In single-shot mode, `active` falls on the edge that forwards the first accepted frame end. Later events are ignored until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command: 0 disable, 1 enable, 2 reset, 3 single-shot |
| evt_in | input | 5 | One-hot stream event from the parser |
| err_clr | input | 1 | Write-one clear of the stream error flag |
| evt_out | output | 5 | Forwarded legal event, one cycle late |
| stream_err | output | 1 | Sticky stream-order violation flag |
| active | output | 1 | Checker is capturing |
| line_cnt | output | CNT_W | Saturating count of lines processed |
| frame_cnt | output | CNT_W | Saturating count of frame starts output |

## Verification
The bound checker checks several properties on every cycle:
- the forwarded events are never multi-hot;
- every forwarded data, line-end or frame-end event follows a legal predecessor;
- the outputs stay silent while the checker is idle;
- the error flag holds without a clear;
- the counters never decrease except on a reset command, and the frame count steps with each forwarded frame start.

Only the bench's scenarios show the other behaviours:
- resynchronisation waits for the next frame start;
- a multi-hot input is rejected;
- the error flag stays set when a violation meets a clear;
- single-shot capture stops after one frame;
- the counters hold at saturation with a narrow counter width.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

    localparam int EVT_W  = 5;
    localparam int EV_FS  = 0;
    localparam int EV_LS  = 1;
    localparam int EV_DAT = 2;
    localparam int EV_LE  = 3;
    localparam int EV_FE  = 4;

    typedef logic [EVT_W-1:0] evt_t;

    typedef enum logic [1:0] {
        OP_DISABLE = 2'd0,
        OP_ENABLE  = 2'd1,
        OP_RESET   = 2'd2,
        OP_SINGLE  = 2'd3
    } pcmd_t;

    typedef enum logic [2:0] {
        ST_WAIT_FS,
        ST_FRAME,
        ST_LINE,
        ST_DATA,
        ST_LINE_DONE
    } seq_st_t;

    // Mask of events that may legally follow the current position.
    function automatic evt_t legal_next(input seq_st_t s);
        evt_t m;
        m = '0;
        case (s)
            ST_WAIT_FS:   m[EV_FS] = 1'b1;
            ST_FRAME:     begin m[EV_LS] = 1'b1; m[EV_FE] = 1'b1; end
            ST_LINE:      begin m[EV_DAT] = 1'b1; m[EV_LE] = 1'b1; end
            ST_DATA:      m[EV_LE] = 1'b1;
            ST_LINE_DONE: begin m[EV_LS] = 1'b1; m[EV_FE] = 1'b1; end
            default:      m = '0;
        endcase
        return m;
    endfunction

    // Position reached after accepting a one-hot event.
    function automatic seq_st_t after_evt(input evt_t e);
        seq_st_t s;
        s = ST_WAIT_FS;
        if (e[EV_FS])       s = ST_FRAME;
        else if (e[EV_LS])  s = ST_LINE;
        else if (e[EV_DAT]) s = ST_DATA;
        else if (e[EV_LE])  s = ST_LINE_DONE;
        return s;
    endfunction

endpackage

// File: rtl/pxs_run_ctrl.sv
module pxs_run_ctrl
    import pxs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       frame_done,
    output logic       active,
    output logic       restart,
    output logic       cnt_clr
);
    pcmd_t op;
    logic  single_q;

    assign op      = pcmd_t'(cmd_op);
    assign restart = cmd_valid && (op == OP_ENABLE || op == OP_SINGLE);
    assign cnt_clr = cmd_valid && (op == OP_RESET);

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            single_q <= 1'b0;
        end else if (cmd_valid) begin
            case (op)
                OP_ENABLE:  begin active <= 1'b1; single_q <= 1'b0; end
                OP_SINGLE:  begin active <= 1'b1; single_q <= 1'b1; end
                default:    active <= 1'b0;
            endcase
        end else if (frame_done && single_q) begin
            active <= 1'b0;
        end
    end
endmodule

// File: rtl/pxs_seq_fsm.sv
module pxs_seq_fsm
    import pxs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    input  evt_t evt,
    output logic accept,
    output logic violate,
    output logic frame_done
);
    seq_st_t st_q;
    logic    present;
    logic    fits;

    assign present    = run && (evt != '0);
    assign fits       = $onehot(evt) && ((evt & legal_next(st_q)) != '0);
    assign accept     = present && fits;
    assign violate    = present && !fits;
    assign frame_done = accept && evt[EV_FE];

    always_ff @(posedge clk) begin
        if (rst || restart)
            st_q <= ST_WAIT_FS;
        else if (accept)
            st_q <= after_evt(evt);
        else if (violate)
            st_q <= ST_WAIT_FS;
    end
endmodule

// File: rtl/pxs_sat_counter.sv
module pxs_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (inc && count != TOP)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/pxs_order_guard.sv
module pxs_order_guard
    import pxs_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [4:0]       evt_in,
    input  logic             err_clr,
    output logic [4:0]       evt_out,
    output logic             stream_err,
    output logic             active,
    output logic [CNT_W-1:0] line_cnt,
    output logic [CNT_W-1:0] frame_cnt
);
    logic restart, cnt_clr, frame_done, accept, violate, run;

    assign run = active && !cmd_valid;

    pxs_run_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .frame_done(frame_done), .active(active), .restart(restart),
        .cnt_clr(cnt_clr)
    );

    pxs_seq_fsm u_seq (
        .clk(clk), .rst(rst), .restart(restart), .run(run), .evt(evt_in),
        .accept(accept), .violate(violate), .frame_done(frame_done)
    );

    pxs_sat_counter #(.W(CNT_W)) u_lines (
        .clk(clk), .rst(rst), .clr(cnt_clr),
        .inc(accept && evt_in[EV_LE]), .count(line_cnt)
    );

    pxs_sat_counter #(.W(CNT_W)) u_frames (
        .clk(clk), .rst(rst), .clr(cnt_clr),
        .inc(accept && evt_in[EV_FS]), .count(frame_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_out    <= '0;
            stream_err <= 1'b0;
        end else begin
            evt_out <= accept ? evt_in : '0;
            if (violate)
                stream_err <= 1'b1;
            else if (err_clr)
                stream_err <= 1'b0;
        end
    end
endmodule

// File: rtl/pxs_order_guard_chk.sv
module pxs_order_guard_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic             err_clr,
    input logic [4:0]       evt_out,
    input logic             stream_err,
    input logic             active,
    input logic [CNT_W-1:0] line_cnt,
    input logic [CNT_W-1:0] frame_cnt
);
    logic [4:0] last_fwd;
    logic       rst_cmd;

    assign rst_cmd = cmd_valid && (cmd_op == 2'd2);

    always_ff @(posedge clk) begin
        if (rst)
            last_fwd <= '0;
        else if (evt_out != '0)
            last_fwd <= evt_out;
    end

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !active |=> evt_out == '0); // R2
    AST_FWD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt_out)); // R4
    AST_DATA_AFTER_LS: assert property (@(posedge clk) disable iff (rst)
        evt_out[2] |-> last_fwd[1]); // R4
    AST_LE_AFTER_LINE: assert property (@(posedge clk) disable iff (rst)
        evt_out[3] |-> (last_fwd[1] || last_fwd[2])); // R4
    AST_FE_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
        evt_out[4] |-> (last_fwd[0] || last_fwd[3])); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        stream_err && !err_clr |=> stream_err); // R8
    AST_FS_COUNTED: assert property (@(posedge clk) disable iff (rst)
        evt_out[0] && $past(frame_cnt) != {CNT_W{1'b1}}
        |-> frame_cnt == CNT_W'($past(frame_cnt) + 1'b1)); // R9
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !rst_cmd |=> (frame_cnt >= $past(frame_cnt)) && (line_cnt >= $past(line_cnt))); // R10
endmodule

bind pxs_order_guard pxs_order_guard_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .err_clr(err_clr), .evt_out(evt_out), .stream_err(stream_err),
    .active(active), .line_cnt(line_cnt), .frame_cnt(frame_cnt)
);

// File: tb/test_pxs_order_guard.sv
`timescale 1ns/1ps
module test_pxs_order_guard;
    localparam int CW = 4;
    localparam logic [4:0] FS = 5'b00001, LS = 5'b00010, DT = 5'b00100,
                           LE = 5'b01000, FE = 5'b10000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [4:0]    evt_in = '0;
    logic          err_clr = 1'b0;
    logic [4:0]    evt_out;
    logic          stream_err, active;
    logic [CW-1:0] line_cnt, frame_cnt;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [4:0] expq[$];

    // model state: 0 wait FS, 1 after FS, 2 in line, 3 after data, 4 after LE
    int mst = 0;
    bit mact = 0, mss = 0, merr = 0;
    int mlines = 0, mframes = 0;
    localparam int MAXC = (1 << CW) - 1;

    always #2.5 clk = ~clk;

    pxs_order_guard #(.CNT_W(CW)) i_pxs_order_guard (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .evt_in(evt_in), .err_clr(err_clr), .evt_out(evt_out),
        .stream_err(stream_err), .active(active),
        .line_cnt(line_cnt), .frame_cnt(frame_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit legal(input int s, input logic [4:0] e);
        if ($countones(e) != 1) return 0;
        case (s)
            0: return e == FS;
            1: return e == LS || e == FE;
            2: return e == DT || e == LE;
            3: return e == LE;
            default: return e == LS || e == FE;
        endcase
    endfunction

    // monitor: compare forwarded events against the expectation queue
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && evt_out != '0) begin
                checks++;
                if (expq.size() == 0) begin
                    errors++;
                    $display("FAIL R4: actual %b expected no event", evt_out);
                end else begin
                    logic [4:0] x;
                    x = expq.pop_front();
                    if (x != evt_out) begin
                        errors++;
                        $display("FAIL R4: actual %b expected %b", evt_out, x);
                    end
                end
            end
        end
    end

    task automatic cmd(input logic [1:0] op);
        cmd_valid = 1'b1; cmd_op = op;
        case (op)
            2'd0: mact = 0;
            2'd1: begin mact = 1; mss = 0; mst = 0; end
            2'd2: begin mact = 0; mlines = 0; mframes = 0; end
            default: begin mact = 1; mss = 1; mst = 0; end
        endcase
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic ev(input logic [4:0] e, input bit clr = 0);
        bit viol;
        viol = 0;
        evt_in = e; err_clr = clr;
        if (mact && e != '0) begin
            if (legal(mst, e)) begin
                expq.push_back(e);
                if (e == FS) begin mst = 1; if (mframes < MAXC) mframes++; end
                else if (e == LS) mst = 2;
                else if (e == DT) mst = 3;
                else if (e == LE) begin mst = 4; if (mlines < MAXC) mlines++; end
                else begin mst = 0; if (mss) mact = 0; end
            end else begin
                viol = 1; mst = 0;
            end
        end
        if (viol) merr = 1; else if (clr) merr = 0;
        @(negedge clk);
        evt_in = '0; err_clr = 1'b0;
    endtask

    task automatic state_chk(input string req);
        chk({req, " err"}, stream_err, merr);
        chk({req, " active"}, active, mact);
        chk({req, " lines"}, line_cnt, mlines);
        chk({req, " frames"}, frame_cnt, mframes);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 out", evt_out, 0);
        state_chk("R1");
        rst = 1'b0;
        @(negedge clk);
        state_chk("R1 post");

        // R2: idle checker ignores events
        ev(FS); ev(LS); ev(LE);
        state_chk("R2 idle");

        // R3 enable, R4 and R9: legal frame with two lines
        cmd(2'd1);
        chk("R3 enable", active, 1);
        ev(FS); ev(LS); ev(DT); ev(LE); ev(LS); ev(LE); ev(FE);
        state_chk("R4 R9 frame");
        // empty frame is legal
        ev(FS); ev(FE);
        state_chk("R4 empty");

        // R5: first event after enable must be frame start
        cmd(2'd1);
        ev(LS);
        state_chk("R5 first");
        // R6: resync on the next frame start, error stays
        ev(DT); ev(FS); ev(LS); ev(FS);
        state_chk("R6 midframe");
        ev(LE);
        state_chk("R6 waiting");
        ev(FS); ev(LS); ev(DT); ev(DT);
        state_chk("R6 double data");

        // R8: clear, then violation plus clear in the same cycle
        ev(5'b0, 1);
        state_chk("R8 clear");
        ev(FS); ev(FS, 1);
        state_chk("R8 set wins");
        ev(5'b0, 1);

        // R7: multi-hot input
        ev(FS); ev(LS | LE);
        state_chk("R7 multihot");
        ev(5'b0, 1);

        // R3: event during a command cycle is ignored
        cmd_valid = 1'b1; cmd_op = 2'd1; evt_in = LS;
        mact = 1; mss = 0; mst = 0;
        @(negedge clk);
        cmd_valid = 1'b0; evt_in = '0;
        state_chk("R3 cmd cycle");

        // R11: single shot stops after one frame
        cmd(2'd3);
        ev(FS); ev(LS); ev(LE); ev(FE);
        state_chk("R11 stop");
        ev(FS);
        state_chk("R11 ignored");

        // R3: reset command clears counters, keeps error
        ev(5'b0);
        cmd(2'd1); ev(LE);
        cmd(2'd2);
        state_chk("R3 reset");
        cmd(2'd0);
        state_chk("R3 disable");
        ev(5'b0, 1);

        // R10: saturation
        cmd(2'd1);
        for (int i = 0; i < 20; i++) begin
            ev(FS); ev(LS); ev(LE); ev(FE);
        end
        state_chk("R10 saturate");

        cmd(2'd0);
        @(negedge clk);
        chk("R4 queue drained", expq.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule